// File: doc/BRIEF.md
# EEPROM serial slave with write-protect flags

This block is a two-wire serial bus target in front of a 256-byte memory array. A master can write single bytes or runs of bytes. It can read from the current pointer, read from an address it loads with a dummy write followed by a repeated START, and keep reading for as long as it acknowledges each byte. The block observes SCL and SDA through a synchronizer clocked by the system clock. It pulls SDA low by asserting `sda_oe`, so the bus stays open-drain.

A second command space guards the lower half of the memory. It keeps two flags: a permanent lock and a reversible lock. A set or clear command carries two dummy bytes and takes effect only at the STOP that closes it. A query returns no data byte. The block answers the device byte itself with ACK when the flag is clear and with NoACK when it is set.

The reversible lock can be reached only when three things hold: the three address pins sit at a fixed pattern, a high-voltage indication on pin A0 is present from before the START until the STOP, and that indication counts as logic 1 on A0. A command that lacks the qualification anywhere in that window acts on the permanent lock instead.

Top module: `eewp_slave`

## Requirements
- R1: A device byte `1010` + A2..A0 + 0 is acknowledged when bits [3:1] equal the pin levels, with A0 read as high when `hv_a0` is set. The byte address that follows is acknowledged. Each data byte after it is acknowledged and stored, and the pointer increments after every stored byte.
- R2: A device byte whose upper nibble is neither `1010` nor `0110` gets NoACK. So does a `1010` byte whose bits [3:1] differ from the pins, or a `0110` byte whose bits [3:1] are not 000, 001 or 011. After a NoACK the block stays released until the next START or STOP.
- R3: A `1010` device byte with R/W=1 returns the byte at the pointer, MSB first. A dummy write of the address, then a repeated START and a read, returns the byte at that address.
- R4: While the master acknowledges, reads return consecutive bytes. After the master sends NoACK, SDA is left released. The pointer wraps from 0xFF to 0x00 on both reads and writes.
- R5: A `0110` command with R/W=1 returns no data byte. Its device byte gets NoACK if the selected flag is set and ACK if it is clear.
- R6: The protection command codes are: bits [3:1] 001 sets the reversible flag, 011 clears it, and 000 sets the permanent flag. A 001 or 011 command is a reversible command only if `hv_a0` has been high since the START, the pins read as 001 with A0 counted high by `hv_a0`, and otherwise it acts on the permanent flag. Permanent commands ignore the pins.
- R7: A set or clear command is acknowledged on its device byte, its dummy address byte and its dummy data byte. It changes a flag only at the STOP that ends it. A repeated START before that STOP discards it.
- R8: If `hv_a0` drops after a reversible set or clear has been decoded and before its STOP, the STOP sets the permanent flag.
- R9: While either flag is set, a data byte aimed at addresses 0x00..0x7F gets NoACK and the memory is left unchanged. Addresses 0x80..0xFF stay writable.
- R10: The permanent flag is never cleared once set. While it is set, every protection set or clear command gets NoACK on its device byte.
- R11: A START or STOP in the middle of a byte aborts the transfer, stores nothing and releases SDA.
- R12: `sda_oe` changes only while SCL is low.
- R13: After reset `sda_oe` is 0, both flags are clear and every memory byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level as seen on the pin |
| sda_in | input | 1 | Bus data level as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| addr_pins | input | 3 | Address pin levels A2..A0 |
| hv_a0 | input | 1 | High-voltage detected on address pin A0 |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the preambles `1010` and `0110`, reversible pin pattern 001, and two synchronizer stages. It ties the pins to 001, so one pin setting serves both the memory device address and the reversible commands. The 8-bit pointer brings the 0xFF-to-0x00 wrap and the 0x7F/0x80 protection edge within a few transfers. Toggling `hv_a0` around START and STOP reaches both the qualified reversible path and its fall-back onto the permanent flag.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
    localparam int ADDR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_ADDR, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK, ST_SKIP
    } st_e;

    typedef struct packed {
        st_e               st;
        st_e               after;   // state entered when the ACK slot ends
        logic [3:0]        bits;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              wp_cmd;  // current transfer is a protection command
        logic              rev;     // decoded as a reversible command
        logic [2:0]        op;
        logic              pend;    // set/clear waiting for STOP
        logic              hv_ok;   // high voltage held since START
        logic              mack;    // master acknowledged last read byte
        logic              pswp;
        logic              rswp;
    } core_t;
endpackage

// File: rtl/eewp_bus_sense.sv
module eewp_bus_sense #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw, cur, prv;
    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [SYNC:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC-1:0], raw[g]};
        end
        assign cur[g] = chain[SYNC-1];
        assign prv[g] = chain[SYNC];
    end

    assign sda_s     = cur[0];
    assign scl_rise  = cur[1] & ~prv[1];
    assign scl_fall  = ~cur[1] & prv[1];
    assign start_det = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign stop_det  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/eewp_mem.sv
module eewp_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eewp_slave.sv
module eewp_slave
    import eewp_pkg::*;
#(
    parameter logic [3:0] MEM_TYPE = 4'b1010,
    parameter logic [3:0] WP_TYPE  = 4'b0110,
    parameter logic [2:0] REV_PINS = 3'b001,
    parameter int         SYNC     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] addr_pins,
    input  logic       hv_a0
);
    localparam logic [2:0] OP_SET_REV  = 3'b001;
    localparam logic [2:0] OP_CLR_REV  = 3'b011;
    localparam logic [2:0] OP_SET_PERM = 3'b000;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic mem_we;
    logic [7:0] rdata;
    logic perm_flag, rev_flag;
    core_t q, n;

    eewp_bus_sense #(.SYNC(SYNC)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_s(sda_s)
    );

    eewp_mem #(.AW(ADDR_W), .DW(8)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(q.ptr), .wdata(q.sh),
        .raddr(q.ptr), .rdata(rdata)
    );

    always_comb begin
        logic       ack;
        logic       qual;
        logic       flag;
        logic [2:0] eff_pins;
        st_e        nxt;
        n        = q;
        mem_we   = 1'b0;
        ack      = 1'b0;
        qual     = 1'b0;
        flag     = 1'b0;
        nxt      = ST_SKIP;
        eff_pins = {addr_pins[2:1], addr_pins[0] | hv_a0};
        n.hv_ok  = q.hv_ok & hv_a0;
        if (start_det) begin
            n.st    = ST_DEV;
            n.bits  = '0;
            n.oe    = 1'b0;
            n.pend  = 1'b0;
            n.hv_ok = hv_a0;
        end else if (stop_det) begin
            if (q.pend) begin
                if (q.rev && q.hv_ok && hv_a0) n.rswp = (q.op == OP_SET_REV);
                else                           n.pswp = 1'b1;
            end
            n.st   = ST_IDLE;
            n.oe   = 1'b0;
            n.pend = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_ADDR, ST_WDAT: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:4] == MEM_TYPE && q.sh[3:1] == eff_pins) begin
                                ack      = 1'b1;
                                n.wp_cmd = 1'b0;
                                nxt      = q.sh[0] ? ST_RDAT : ST_ADDR;
                            end else if (q.sh[7:4] == WP_TYPE &&
                                         (q.sh[3:1] == OP_SET_REV || q.sh[3:1] == OP_CLR_REV ||
                                          q.sh[3:1] == OP_SET_PERM)) begin
                                qual     = q.hv_ok && hv_a0 && eff_pins == REV_PINS &&
                                           q.sh[3:1] != OP_SET_PERM;
                                n.wp_cmd = 1'b1;
                                n.rev    = qual;
                                n.op     = q.sh[3:1];
                                if (q.sh[0]) begin
                                    flag = qual ? q.rswp : q.pswp;
                                    ack  = ~flag;
                                end else begin
                                    ack = ~q.pswp;
                                    nxt = q.pswp ? ST_SKIP : ST_ADDR;
                                end
                            end
                        end else if (q.st == ST_ADDR) begin
                            ack = 1'b1;
                            nxt = ST_WDAT;
                            if (!q.wp_cmd) n.ptr = q.sh[ADDR_W-1:0];
                        end else if (q.wp_cmd) begin
                            ack    = 1'b1;
                            n.pend = 1'b1;
                        end else if (!((q.pswp || q.rswp) && !q.ptr[ADDR_W-1])) begin
                            ack    = 1'b1;
                            mem_we = 1'b1;
                            n.ptr  = q.ptr + ADDR_W'(1);
                            nxt    = ST_WDAT;
                        end
                        n.bits  = '0;
                        n.oe    = ack;
                        n.after = ack ? nxt : ST_SKIP;
                        n.st    = ST_ACK;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    n.oe   = 1'b0;
                    n.bits = '0;
                    n.st   = q.after;
                    if (q.after == ST_RDAT) begin
                        n.sh  = rdata;
                        n.ptr = q.ptr + ADDR_W'(1);
                        n.oe  = ~rdata[7];
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        n.bits = q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            n.oe   = 1'b0;
                            n.bits = '0;
                            n.st   = ST_RACK;
                        end else begin
                            n.sh = {q.sh[6:0], 1'b0};
                            n.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            n.sh  = rdata;
                            n.ptr = q.ptr + ADDR_W'(1);
                            n.oe  = ~rdata[7];
                            n.st  = ST_RDAT;
                        end else begin
                            n.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.after <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_oe    = q.oe;
    assign perm_flag = q.pswp;
    assign rev_flag  = q.rswp;
endmodule

// File: rtl/eewp_checker.sv
module eewp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       stop_det,
    input logic       perm_flag,
    input logic       rev_flag,
    input logic       mem_we,
    input logic [7:0] mem_waddr
);
    assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    assert_perm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        perm_flag |=> perm_flag);

    assert_rev_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev_flag) |-> $past(stop_det));

    assert_perm_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perm_flag) |-> $past(stop_det));

    assert_low_half_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_waddr[7]) |-> !(perm_flag || rev_flag));

    assert_release_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind eewp_slave eewp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .stop_det(stop_det), .perm_flag(perm_flag), .rev_flag(rev_flag),
    .mem_we(mem_we), .mem_waddr(q.ptr)
);

// File: tb/eewp_slave_tb.sv
module eewp_slave_tb;
    localparam int CLK_P = 10;
    localparam int HQ    = 4 * CLK_P;   // quarter of an SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       hv = 1'b0;
    logic [2:0] pins = 3'b001;
    logic       sda_oe;
    logic       sda_bus;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    eewp_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .addr_pins(pins), .hv_a0(hv)
    );

    int    total = 0;
    int    bad = 0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_val;
    int    e_val;
    string e_tag;
    event  obs_ev;

    task automatic push_exp(input int v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic observe(input int v);
        obs_val = v;
        ->obs_ev;
        #1;
    endtask

    // monitor: pops expectations as the bus yields results
    initial forever begin
        @(obs_ev);
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected result: actual %0h expected none", obs_val);
        end else begin
            e_val = exp_q.pop_front();
            e_tag = tag_q.pop_front();
            if (e_val != obs_val) begin
                bad++;
                $display("FAIL %s: actual %0h expected %0h", e_tag, obs_val, e_val);
            end
        end
    end

    task automatic bit_out(input logic b);
        #HQ m_sda = b;
        #HQ scl = 1'b1;
        #(2*HQ) scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        #HQ m_sda = 1'b1;
        #HQ scl = 1'b1;
        #HQ b = sda_bus;
        #HQ scl = 1'b0;
    endtask

    task automatic bus_start();
        #HQ m_sda = 1'b1;
        #HQ scl = 1'b1;
        #HQ m_sda = 1'b0;
        #HQ scl = 1'b0;
    endtask

    task automatic bus_stop();
        #HQ m_sda = 1'b0;
        #HQ scl = 1'b1;
        #HQ m_sda = 1'b1;
        #HQ;
    endtask

    // send a byte; expected ack value: 0 = ACK, 1 = NoACK
    task automatic tx(input logic [7:0] b, input int ea, input string t);
        logic a;
        push_exp(ea, t);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        observe(int'(a));
    endtask

    task automatic rx(input logic [7:0] eb, input bit more, input string t);
        logic [7:0] v;
        logic       b;
        push_exp(int'(eb), t);
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        observe(int'(v));
        bit_out(more ? 1'b0 : 1'b1);
    endtask

    task automatic read_at(input logic [7:0] a, input logic [7:0] eb, input string t);
        bus_start(); tx(8'hA2, 0, t); tx(a, 0, t);
        bus_start(); tx(8'hA3, 0, t); rx(eb, 0, t); bus_stop();
    endtask

    task automatic wp_write(input logic [7:0] dev, input int ea, input string t);
        bus_start(); tx(dev, ea, t);
        if (ea == 0) begin tx(8'h00, 0, t); tx(8'h00, 0, t); end
        bus_stop();
    endtask

    task automatic wp_query(input logic [7:0] dev, input int ea, input string t);
        bus_start(); tx(dev, ea, t); bus_stop();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        #3;
        #(5*CLK_P) rst_n = 1'b1;
        #(5*CLK_P);
        total++;
        if (sda_oe !== 1'b0) begin
            bad++;
            $display("FAIL R13 reset: actual %0b expected 0", sda_oe);
        end
        // R1 byte write, R3 selective read, R13 erased array
        bus_start(); tx(8'hA2, 0, "R1 dev"); tx(8'h10, 0, "R1 addr"); tx(8'h5A, 0, "R1 data"); bus_stop();
        read_at(8'h10, 8'h5A, "R3 selective");
        read_at(8'h44, 8'h00, "R13 erased");
        // R2 mismatching pins, foreign preamble, bad op
        wp_query(8'hA6, 1, "R2 pins mismatch");
        wp_query(8'hB2, 1, "R2 foreign type");
        wp_query(8'h6A, 1, "R2 bad op");
        // R4 multi-byte write and sequential read
        bus_start(); tx(8'hA2, 0, "R4"); tx(8'h11, 0, "R4"); tx(8'h66, 0, "R4"); tx(8'h77, 0, "R4"); bus_stop();
        bus_start(); tx(8'hA2, 0, "R4"); tx(8'h10, 0, "R4");
        bus_start(); tx(8'hA3, 0, "R4"); rx(8'h5A, 1, "R4 n"); rx(8'h66, 1, "R4 n+1"); rx(8'h77, 0, "R4 n+2"); bus_stop();
        // R4 wrap on write and read
        bus_start(); tx(8'hA2, 0, "R4 wrap"); tx(8'hFF, 0, "R4 wrap"); tx(8'hC3, 0, "R4 wrap"); tx(8'h3C, 0, "R4 wrap"); bus_stop();
        bus_start(); tx(8'hA2, 0, "R4 wrap"); tx(8'hFF, 0, "R4 wrap");
        bus_start(); tx(8'hA3, 0, "R4 wrap"); rx(8'hC3, 1, "R4 at FF"); rx(8'h3C, 0, "R4 at 00"); bus_stop();
        // R3 current read continues at 0x01
        bus_start(); tx(8'hA3, 0, "R3 current"); rx(8'h00, 0, "R3 current data"); bus_stop();
        // R5 queries with both flags clear
        wp_query(8'h61, 0, "R5 perm clear");
        hv = 1'b1;
        wp_query(8'h63, 0, "R5 rev clear");
        // R6 set reversible, then query both ways
        wp_write(8'h62, 0, "R6 set rev");
        wp_query(8'h63, 1, "R5 rev set");
        hv = 1'b0;
        wp_query(8'h63, 0, "R6 unqualified query reads perm");
        wp_query(8'h61, 0, "R6 perm still clear");
        // R9 protection of lower half only
        bus_start(); tx(8'hA2, 0, "R9"); tx(8'h20, 0, "R9"); tx(8'h11, 1, "R9 low NoACK"); bus_stop();
        read_at(8'h20, 8'h00, "R9 low unchanged");
        bus_start(); tx(8'hA2, 0, "R9"); tx(8'h90, 0, "R9"); tx(8'hAB, 0, "R9 high ACK"); bus_stop();
        read_at(8'h90, 8'hAB, "R9 high stored");
        // R7 clear discarded by repeated START
        hv = 1'b1;
        bus_start(); tx(8'h66, 0, "R7 clr"); tx(8'h00, 0, "R7"); tx(8'h00, 0, "R7");
        bus_start(); tx(8'h63, 1, "R7 not cleared yet"); bus_stop();
        wp_write(8'h66, 0, "R7 clr");
        wp_query(8'h63, 0, "R7 cleared at STOP");
        hv = 1'b0;
        bus_start(); tx(8'hA2, 0, "R7"); tx(8'h20, 0, "R7"); tx(8'h11, 0, "R7 low writable"); bus_stop();
        read_at(8'h20, 8'h11, "R7 low stored");
        // R11 STOP in the middle of a data byte
        bus_start(); tx(8'hA2, 0, "R11"); tx(8'h30, 0, "R11");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_stop();
        read_at(8'h30, 8'h00, "R11 aborted byte");
        // R8 high voltage dropped before STOP
        hv = 1'b1;
        bus_start(); tx(8'h62, 0, "R8"); tx(8'h00, 0, "R8"); tx(8'h00, 0, "R8");
        hv = 1'b0;
        bus_stop();
        wp_query(8'h61, 1, "R8 perm set");
        hv = 1'b1;
        wp_query(8'h63, 0, "R8 rev untouched");
        // R10 permanent lock refuses set and clear
        wp_query(8'h66, 1, "R10 clear refused");
        wp_query(8'h60, 1, "R10 set refused");
        hv = 1'b0;
        wp_query(8'h61, 1, "R10 perm sticky");
        bus_start(); tx(8'hA2, 0, "R10"); tx(8'h40, 0, "R10"); tx(8'h99, 1, "R10 low NoACK"); bus_stop();
        read_at(8'h40, 8'h00, "R10 low unchanged");
        #(20*CLK_P);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL leftover: actual %0d expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule